// File: doc/BRIEF.md
# Trimmable Seconds Prescaler

This block turns a 32768 Hz clock-enable into a one-cycle pulse once per second. It uses two chained stages: a low stage that divides by 2^LO_W (256 by default, so it wraps 128 times per second) and a high stage that divides by 2^HI_W (128 by default). Software can correct drift through one 32-bit write port, using two independent trims.

The coarse trim works periodically. Once every N+1 seconds it either adds one extra tick pulse or drops one tick pulse. The fine trim is one-shot. A single write lengthens or shortens the current second by exactly one low-stage period, which is 1/128 s at the default sizes. A busy flag stays high from the fine-trim write until the correction has been applied at the next low-stage wrap. The seconds counter that consumes the tick and the clock source lie outside this block.

Top module: `seconds_prescaler_trim`

## Requirements
- R1: With no trim active, `sec_tick_o` is high for exactly one cycle. That cycle directly follows the clock edge that accepts enable number k·2^(LO_W+HI_W), counted from reset. It is never high on three consecutive cycles.
- R2: While `rst_ni` is low, `sec_tick_o` and `fine_busy_o` are 0. Both prescaler stages restart from zero after reset.
- R3: The prescaler advances only on cycles where `tick32k_i` is high. A first tick pulse is always preceded by an accepted enable.
- R4: When the coarse valid bit 23 is 1 and mode field [20:19] = 3, every (N+1)-th second gets a second tick pulse in the cycle directly after the regular one. N is field [18:0].
- R5: When the coarse valid bit 23 is 1 and mode field [20:19] = 2, the tick of every (N+1)-th second is suppressed. With N = 0, every tick is suppressed.
- R6: When bit 23 is 0, or when mode is 0 or 1, no coarse adjustment happens and ticks stay as in R1.
- R7: Every write reloads the internal second-interval counter with the written N. The counter also reloads with N after each coarse adjustment.
- R8: A write with bit 25 = 1 applies exactly one correction at the next low-stage wrap. With bit 24 = 1, one low-stage period is inserted, so the next tick comes 2^LO_W enables late. With bit 24 = 0, one low-stage period is removed, so the next tick comes 2^LO_W enables early. All later ticks keep the new phase.
- R9: `fine_busy_o` is 1 from the cycle after a fine-trim write. It falls at the low-stage wrap where the correction is applied, and it rises only after such a write.
- R10: A write with bit 25 = 0 starts no fine trim: `fine_busy_o` stays 0 and the tick timing is unchanged, even when bit 24 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | 32768 Hz clock-enable, one cycle per pulse |
| wr_en_i | input | 1 | Write strobe for the adjust word |
| wr_data_i | input | 32 | Adjust word: [18:0] N, [20:19] coarse mode, 23 coarse valid, 24 fine direction, 25 fine valid |
| sec_tick_o | output | 1 | One-cycle seconds tick |
| fine_busy_o | output | 1 | Fine trim pending |

## Verification
The bench tests the coarse interval at N = 0, 1 and 2. An off-by-one interval counter would move the doubled or missing pulse by one second. It also rewrites the adjust word in the middle of an interval. A design that fails to reload on writes would double the pulse one second too early. Both fine directions are checked against the shifted tick phase and the busy window. A design that stepped the high stage wrongly would be 2^LO_W enables off, and a design that let an invalid fine write through would raise busy. Gating the enable to every third cycle catches a prescaler that counts clocks instead of enables.

// File: rtl/secpre_pkg.sv
package secpre_pkg;
  localparam int WR_W       = 32;
  localparam int MATCH_W    = 19;
  localparam int MODE_LSB   = 19;
  localparam int CVALID_BIT = 23;
  localparam int FDIR_BIT   = 24;
  localparam int FVALID_BIT = 25;

  typedef enum logic [1:0] {
    CM_OFF0    = 2'd0,
    CM_OFF1    = 2'd1,
    CM_SWALLOW = 2'd2,
    CM_INSERT  = 2'd3
  } coarse_mode_e;

  typedef struct packed {
    logic               valid;
    coarse_mode_e       mode;
    logic [MATCH_W-1:0] match;
  } coarse_cfg_t;
endpackage

// File: rtl/secpre_regs.sv
module secpre_regs
  import secpre_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WR_W-1:0]    wr_data_i,
  input  logic               fine_done_i,
  output coarse_cfg_t        cfg_o,
  output logic               reload_o,
  output logic [MATCH_W-1:0] reload_val_o,
  output logic               fine_pend_o,
  output logic               fine_ins_o
);
  logic fine_wr;
  logic unused_spare;

  assign fine_wr      = wr_en_i && wr_data_i[FVALID_BIT];
  assign reload_o     = wr_en_i;
  assign reload_val_o = wr_data_i[MATCH_W-1:0];
  assign unused_spare = ^{wr_data_i[WR_W-1:FVALID_BIT+1], wr_data_i[CVALID_BIT-1:MODE_LSB+2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_en_i) begin
      cfg_o.valid <= wr_data_i[CVALID_BIT];
      cfg_o.mode  <= coarse_mode_e'(wr_data_i[MODE_LSB+1:MODE_LSB]);
      cfg_o.match <= wr_data_i[MATCH_W-1:0];
    end
  end

  // a new fine write wins over the completion of an older one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_pend_o <= 1'b0;
      fine_ins_o  <= 1'b0;
    end else if (fine_wr) begin
      fine_pend_o <= 1'b1;
      fine_ins_o  <= wr_data_i[FDIR_BIT];
    end else if (fine_done_i) begin
      fine_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/secpre_chain.sv
module secpre_chain #(
  parameter int LO_W = 8,
  parameter int HI_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fine_pend_i,
  input  logic fine_ins_i,
  output logic fine_done_o,
  output logic raw_sec_o
);
  localparam int SUM_W = HI_W + 1;

  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             lo_wrap;
  logic [1:0]       hi_step;
  logic [SUM_W-1:0] hi_sum;

  assign lo_wrap     = en_i && (lo_q == {LO_W{1'b1}});
  assign fine_done_o = lo_wrap && fine_pend_i;

  // step 0 stretches the second by one low period, step 2 shortens it
  always_comb begin
    hi_step = 2'd0;
    if (lo_wrap) begin
      if (!fine_pend_i)     hi_step = 2'd1;
      else if (!fine_ins_i) hi_step = 2'd2;
    end
  end

  assign hi_sum    = SUM_W'(hi_q) + SUM_W'(hi_step);
  assign raw_sec_o = hi_sum[HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (en_i) begin
      lo_q <= lo_q + LO_W'(1);
      hi_q <= hi_sum[HI_W-1:0];
    end
  end
endmodule

// File: rtl/secpre_coarse.sv
module secpre_coarse
  import secpre_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               raw_sec_i,
  input  logic               reload_i,
  input  logic [MATCH_W-1:0] reload_val_i,
  input  coarse_cfg_t        cfg_i,
  output logic               sec_tick_o
);
  logic [MATCH_W-1:0] gap_q;
  logic               dup_q;
  logic               adj_on;
  logic               due;
  logic               ins_now;
  logic               swl_now;

  assign adj_on  = cfg_i.valid && (cfg_i.mode == CM_INSERT || cfg_i.mode == CM_SWALLOW);
  assign due     = raw_sec_i && !reload_i && adj_on && (gap_q == '0);
  assign ins_now = due && (cfg_i.mode == CM_INSERT);
  assign swl_now = due && (cfg_i.mode == CM_SWALLOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (reload_i) begin
      gap_q <= reload_val_i;
    end else if (raw_sec_i && adj_on) begin
      gap_q <= (gap_q == '0) ? cfg_i.match : gap_q - MATCH_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dup_q      <= 1'b0;
      sec_tick_o <= 1'b0;
    end else begin
      dup_q      <= ins_now;
      sec_tick_o <= (raw_sec_i && !swl_now) || dup_q;
    end
  end
endmodule

// File: rtl/seconds_prescaler_trim.sv
module seconds_prescaler_trim
  import secpre_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick32k_i,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            sec_tick_o,
  output logic            fine_busy_o
);
  coarse_cfg_t        cfg_q;
  logic               reload;
  logic [MATCH_W-1:0] reload_val;
  logic               fine_pend;
  logic               fine_ins;
  logic               fine_done;
  logic               raw_sec;

  secpre_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .fine_done_i  (fine_done),
    .cfg_o        (cfg_q),
    .reload_o     (reload),
    .reload_val_o (reload_val),
    .fine_pend_o  (fine_pend),
    .fine_ins_o   (fine_ins)
  );

  secpre_chain #(.LO_W(LO_W), .HI_W(HI_W)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tick32k_i),
    .fine_pend_i (fine_pend),
    .fine_ins_i  (fine_ins),
    .fine_done_o (fine_done),
    .raw_sec_o   (raw_sec)
  );

  secpre_coarse u_coarse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raw_sec_i    (raw_sec),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .cfg_i        (cfg_q),
    .sec_tick_o   (sec_tick_o)
  );

  assign fine_busy_o = fine_pend;
endmodule

// File: rtl/seconds_prescaler_trim_chk.sv
module seconds_prescaler_trim_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick32k_i,
  input logic fine_wr_i,
  input logic ins_sel_i,
  input logic sec_tick_o,
  input logic fine_busy_o
);
  a_r9_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_wr_i |=> fine_busy_o);

  a_r9_busy_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fine_busy_o) |-> $past(fine_wr_i));

  a_r8_apply_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fine_busy_o) |-> $past(tick32k_i));

  a_r1_no_triple_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && $past(sec_tick_o)) |=> !sec_tick_o);

  a_r3_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && !$past(sec_tick_o)) |-> $past(tick32k_i));

  a_r4_dup_only_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && $past(sec_tick_o)) |-> $past(ins_sel_i, 2));
endmodule

bind seconds_prescaler_trim seconds_prescaler_trim_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick32k_i   (tick32k_i),
  .fine_wr_i   (wr_en_i && wr_data_i[secpre_pkg::FVALID_BIT]),
  .ins_sel_i   (cfg_q.valid && (cfg_q.mode == secpre_pkg::CM_INSERT)),
  .sec_tick_o  (sec_tick_o),
  .fine_busy_o (fine_busy_o)
);

// File: tb/seconds_prescaler_trim_tb_top.sv
module seconds_prescaler_trim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 3;
  localparam int HI_W = 2;
  localparam int SEC  = 1 << (LO_W + HI_W);
  localparam int SUB  = 1 << LO_W;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick32k_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        sec_tick_o;
  logic        fine_busy_o;

  int total = 0;
  int bad = 0;
  int en_seen = 0;
  int en_per = 1;
  int ph = 0;
  int cyc = 0;
  int last_cyc = -10;
  int q_en[$];
  bit q_dup[$];
  string q_req[$];
  int m_en;
  bit m_dup;
  string m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  seconds_prescaler_trim #(.LO_W(LO_W), .HI_W(HI_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick32k_i   (tick32k_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .sec_tick_o  (sec_tick_o),
    .fine_busy_o (fine_busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // enables accepted by the design since reset
  always @(posedge clk) begin
    if (!rst_ni) en_seen <= 0;
    else if (tick32k_i) en_seen <= en_seen + 1;
  end

  always @(negedge clk) begin
    ph = ph + 1;
    tick32k_i = ((ph % en_per) == 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_ni && sec_tick_o) begin
      if (q_en.size() == 0) begin
        chk(1'b0, "R1 unexpected tick", en_seen, -1);
      end else begin
        m_en  = q_en.pop_front();
        m_dup = q_dup.pop_front();
        m_req = q_req.pop_front();
        if (m_dup) chk(cyc == last_cyc + 1, m_req, cyc - last_cyc, 1);
        else       chk(en_seen == m_en, m_req, en_seen, m_en);
      end
      last_cyc = cyc;
    end
  end

  task automatic expect_tick(input int en, input bit dup, input string req);
    q_en.push_back(en);
    q_dup.push_back(dup);
    q_req.push_back(req);
  endtask

  task automatic wait_en(input int n);
    while (en_seen != n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic do_reset(input int per);
    rst_ni = 1'b0;
    en_per = per;
    repeat (3) @(negedge clk);
    chk(sec_tick_o == 1'b0, "R2 tick in reset", sec_tick_o, 0);
    chk(fine_busy_o == 1'b0, "R2 busy in reset", fine_busy_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic end_scn(input int n, input string req);
    wait_en(n);
    repeat (2) @(negedge clk);
    chk(q_en.size() == 0, req, q_en.size(), 0);
    q_en.delete(); q_dup.delete(); q_req.delete();
  endtask

  function automatic logic [31:0] coarse_word(input bit v, input int mode, input int n);
    return (32'(v) << 23) | (32'(mode) << 19) | 32'(n);
  endfunction

  initial begin
    // R1 plain division
    do_reset(1);
    expect_tick(SEC, 0, "R1"); expect_tick(2*SEC, 0, "R1"); expect_tick(3*SEC, 0, "R1");
    end_scn(3*SEC + 4, "R1 missing tick");

    // R3 gated enable
    do_reset(3);
    expect_tick(SEC, 0, "R3"); expect_tick(2*SEC, 0, "R3");
    end_scn(2*SEC + 6, "R3 missing tick");

    // R4 insert every 3rd second
    do_reset(1);
    expect_tick(SEC, 0, "R4"); expect_tick(2*SEC, 0, "R4");
    expect_tick(3*SEC, 0, "R4"); expect_tick(0, 1, "R4 dup");
    expect_tick(4*SEC, 0, "R4"); expect_tick(5*SEC, 0, "R4");
    expect_tick(6*SEC, 0, "R4"); expect_tick(0, 1, "R4 dup");
    wait_en(4); wr(coarse_word(1, 3, 2));
    end_scn(6*SEC + 8, "R4 missing tick");

    // R5 swallow every 2nd second
    do_reset(1);
    expect_tick(SEC, 0, "R5"); expect_tick(3*SEC, 0, "R5"); expect_tick(5*SEC, 0, "R5");
    wait_en(4); wr(coarse_word(1, 2, 1));
    end_scn(5*SEC + 8, "R5 missing tick");

    // R5 swallow with N=0 drops every tick
    do_reset(1);
    wait_en(4); wr(coarse_word(1, 2, 0));
    end_scn(3*SEC + 4, "R5 n0");

    // R6 invalid or neutral coarse modes
    do_reset(1);
    expect_tick(SEC, 0, "R6 valid0"); expect_tick(2*SEC, 0, "R6 mode1");
    wait_en(4); wr(coarse_word(0, 3, 0));
    wait_en(SEC + 8); wr(coarse_word(1, 1, 0));
    end_scn(2*SEC + 8, "R6 missing tick");

    // R7 rewrite mid-interval reloads N
    do_reset(1);
    expect_tick(SEC, 0, "R7"); expect_tick(2*SEC, 0, "R7");
    expect_tick(3*SEC, 0, "R7"); expect_tick(0, 1, "R7 dup");
    expect_tick(4*SEC, 0, "R7");
    expect_tick(5*SEC, 0, "R7"); expect_tick(0, 1, "R7 dup");
    wait_en(4); wr(coarse_word(1, 3, 1));
    wait_en(SEC + 8); wr(coarse_word(1, 3, 1));
    end_scn(5*SEC + 8, "R7 missing tick");

    // R8/R9 fine remove
    do_reset(1);
    expect_tick(SEC - SUB, 0, "R8 remove");
    expect_tick(2*SEC - SUB, 0, "R8 remove");
    expect_tick(3*SEC - SUB, 0, "R8 remove");
    wait_en(4); wr(32'h1 << 25);
    chk(fine_busy_o == 1'b1, "R9 busy set", fine_busy_o, 1);
    wait_en(SUB - 1);
    chk(fine_busy_o == 1'b1, "R9 busy held", fine_busy_o, 1);
    wait_en(SUB);
    chk(fine_busy_o == 1'b0, "R9 busy clear", fine_busy_o, 0);
    end_scn(3*SEC - SUB + 4, "R8 missing tick");

    // R8 fine insert
    do_reset(1);
    expect_tick(SEC + SUB, 0, "R8 insert");
    expect_tick(2*SEC + SUB, 0, "R8 insert");
    wait_en(4); wr((32'h1 << 25) | (32'h1 << 24));
    chk(fine_busy_o == 1'b1, "R9 busy insert", fine_busy_o, 1);
    wait_en(SUB);
    chk(fine_busy_o == 1'b0, "R9 busy insert clear", fine_busy_o, 0);
    end_scn(2*SEC + SUB + 4, "R8 missing tick");

    // R10 write without fine valid
    do_reset(1);
    expect_tick(SEC, 0, "R10"); expect_tick(2*SEC, 0, "R10");
    wait_en(4); wr(32'h1 << 24);
    chk(fine_busy_o == 1'b0, "R10 busy", fine_busy_o, 0);
    end_scn(2*SEC + 4, "R10 missing tick");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=0", WD_CYCLES);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule